// File: doc/BRIEF.md
# Serial EEPROM Responder

This block stands in for a small serial EEPROM that a host processor controls one bit at a time through two 16-bit parallel registers. One is a direction register and the other is a data register. Every accepted write to the data register acts as one serial clock. A write carries the host's serial bit in bit 5. A read of the data register returns the device's serial bit in bit 4.

A transaction begins when the host returns the sequencer to its idle state through the direction register. The host then sends one start write, a two-bit opcode and a six-bit word address. After that, the block streams 16-bit words in the direction the opcode selects. The address steps to the next word by itself, and it wraps at the top of the array. The storage holds 64 words of 16 bits. Reset does not clear the storage.

Top module: `serial_eeprom_resp`

## Requirements
- R1: A write to either register is accepted only when bits 7 and 6 of the written value are both 1. Any other write leaves the direction field, the sequencer and the storage unchanged.
- R2: An accepted direction-register write loads bits 5:4 of the value into the `pio_dir` output.
- R3: An accepted direction-register write with bits 5:4 equal to binary 10 returns the sequencer to idle, so the next data write starts a new transaction. The values 00, 01 and 11 leave a transaction in progress undisturbed.
- R4: From idle, the first accepted data write is a start bit. The next two writes supply the opcode from bit 5, first bit into opcode bit 1. Opcode binary 10 is read and binary 01 is write.
- R5: The next six accepted data writes supply the word address from bit 5, most significant bit first. The sequencer then enters the transfer phase.
- R6: In a write transfer, each accepted data write stores its bit 5 into the current word, from bit 15 down to bit 0. After bit 0 the address advances by one.
- R7: In a read transfer, the first data-register read returns 0 (a dummy bit). Each later read returns the next stored bit, bit 15 first, in bit 4 of `rd_data`, with all other bits 0. After bit 0 the address advances by one.
- R8: `rd_data` is 0 whenever no data-register read is strobed, the sequencer is outside the transfer phase, or the opcode is not read. Such reads do not advance the stream.
- R9: The word address wraps from 63 to 0 during multi-word streaming.
- R10: With opcode 00 or 11, data writes in the transfer phase change no stored word, and data reads return 0.
- R11: A synchronous active-low reset sets the sequencer to idle, `pio_dir` to 0 and the bit position to 0. Stored words keep their values.
- R12: A read strobe with the direction register selected returns 0 and does not advance a read stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_stb | input | 1 | Register write strobe, one access per cycle high |
| wr_sel | input | 1 | Write target: 0 direction register, 1 data register |
| wr_data | input | 16 | Value written |
| rd_stb | input | 1 | Register read strobe, one access per cycle high |
| rd_sel | input | 1 | Read target: 0 direction register, 1 data register |
| rd_data | output | 16 | Read value, valid in the cycle `rd_stb` is high |
| pio_dir | output | 2 | Direction field last accepted |

## Verification
The assertions assume that a read strobe and a write strobe never fall in the same cycle. When both are high, the write takes priority in the sequencer and the read step is lost, and the stability and address-step checks rely on that case not occurring. Every bench task issues exactly one strobe per access and leaves an idle cycle between accesses, so stimulus never overlaps. The bench reads back only words it has itself written first, because storage is never initialised and would read as unknown.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OP_HI,
      ST_OP_LO,
      ST_ADDR,
      ST_XFER
   } seq_state_t;

   localparam logic [1:0] OP_WR = 2'b01;
   localparam logic [1:0] OP_RD = 2'b10;
endpackage

// File: rtl/eeprom_seq.sv
module eeprom_seq
   import eeprom_pkg::*;
#(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 6,
   localparam int CNT_W = $clog2(DATA_W),
   localparam int AB_W  = (ADDR_W > 1) ? $clog2(ADDR_W) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dat_wr,
   input  logic              dir_rst,
   input  logic              sin,
   input  logic              rd_req,
   output seq_state_t        state,
   output logic [1:0]        op,
   output logic [ADDR_W-1:0] addr,
   output logic [CNT_W-1:0]  cnt,
   output logic              prime,
   output logic              wr_step
);
   logic [AB_W-1:0] abit;
   logic            rd_step;
   logic            cnt_last;

   assign wr_step  = dat_wr && (state == ST_XFER) && (op == OP_WR);
   assign rd_step  = rd_req && (state == ST_XFER) && (op == OP_RD);
   assign cnt_last = (cnt == CNT_W'(DATA_W - 1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         op    <= '0;
         addr  <= '0;
         abit  <= '0;
         cnt   <= '0;
         prime <= 1'b0;
      end else if (dir_rst) begin
         state <= ST_IDLE;
      end else if (dat_wr) begin
         case (state)
            ST_IDLE: begin
               op    <= '0;
               state <= ST_OP_HI;
            end
            ST_OP_HI: begin
               op[1] <= sin;
               cnt   <= '0;
               prime <= 1'b1;
               state <= ST_OP_LO;
            end
            ST_OP_LO: begin
               op[0] <= sin;
               abit  <= '0;
               state <= ST_ADDR;
            end
            ST_ADDR: begin
               addr <= {addr[ADDR_W-2:0], sin};
               if (abit == AB_W'(ADDR_W - 1)) state <= ST_XFER;
               else abit <= abit + 1'b1;
            end
            ST_XFER: begin
               if (wr_step) begin
                  if (cnt_last) begin
                     cnt  <= '0;
                     addr <= addr + 1'b1;
                  end else begin
                     cnt <= cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end else if (rd_step) begin
         if (prime) begin
            prime <= 1'b0;
         end else if (cnt_last) begin
            cnt  <= '0;
            addr <= addr + 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end
endmodule

// File: rtl/eeprom_store.sv
module eeprom_store #(
   parameter int DATA_W = 16,
   parameter int ADDR_W = 6,
   localparam int CNT_W = $clog2(DATA_W),
   localparam int WORDS = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [CNT_W-1:0]  bit_sel,
   input  logic              bit_val,
   output logic [DATA_W-1:0] rd_word
);
   logic [WORDS-1:0][DATA_W-1:0] flat;

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (we && (addr == ADDR_W'(w))) word_q[bit_sel] <= bit_val;
      end
      assign flat[w] = word_q;
   end

   assign rd_word = flat[addr];
endmodule

// File: rtl/serial_eeprom_resp.sv
module serial_eeprom_resp
   import eeprom_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 6,
   parameter int QUAL_LO  = 6,
   parameter int DIR_LO   = 4,
   parameter int SIN_BIT  = 5,
   parameter int SOUT_BIT = 4,
   localparam int CNT_W   = $clog2(DATA_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_stb,
   input  logic              wr_sel,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_stb,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   output logic [1:0]        pio_dir
);
   if (ADDR_W < 2) begin : g_bad_aw
      $error("ADDR_W must be at least 2");
   end
   if (DATA_W < 2 || (1 << CNT_W) != DATA_W) begin : g_bad_dw
      $error("DATA_W must be a power of two of at least 2");
   end
   if (QUAL_LO + 1 >= DATA_W || DIR_LO + 1 >= DATA_W ||
       SIN_BIT >= DATA_W || SOUT_BIT >= DATA_W) begin : g_bad_pos
      $error("field positions must lie inside the register width");
   end

   logic              qual_ok, dir_wr, dat_wr, dir_rst, rd_req;
   seq_state_t        state;
   logic [1:0]        op;
   logic [ADDR_W-1:0] addr;
   logic [CNT_W-1:0]  cnt, bidx;
   logic              prime, wr_step;
   logic [DATA_W-1:0] rd_word;
   logic              unused_bits;

   assign unused_bits = ^wr_data;
   assign qual_ok = (wr_data[QUAL_LO+1:QUAL_LO] == 2'b11);
   assign dir_wr  = wr_stb && !wr_sel && qual_ok;
   assign dat_wr  = wr_stb && wr_sel && qual_ok;
   assign dir_rst = dir_wr && (wr_data[DIR_LO+1:DIR_LO] == 2'b10);
   assign rd_req  = rd_stb && rd_sel;
   assign bidx    = CNT_W'(DATA_W - 1) - cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) pio_dir <= '0;
      else if (dir_wr) pio_dir <= wr_data[DIR_LO+1:DIR_LO];
   end

   eeprom_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .dat_wr  (dat_wr),
      .dir_rst (dir_rst),
      .sin     (wr_data[SIN_BIT]),
      .rd_req  (rd_req),
      .state   (state),
      .op      (op),
      .addr    (addr),
      .cnt     (cnt),
      .prime   (prime),
      .wr_step (wr_step)
   );

   eeprom_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_store (
      .clk     (clk),
      .we      (wr_step),
      .addr    (addr),
      .bit_sel (bidx),
      .bit_val (wr_data[SIN_BIT]),
      .rd_word (rd_word)
   );

   always_comb begin
      rd_data = '0;
      if (rd_req && (state == ST_XFER) && (op == OP_RD) && !prime)
         rd_data[SOUT_BIT] = rd_word[bidx];
   end
endmodule

// File: rtl/serial_eeprom_resp_chk.sv
module serial_eeprom_resp_chk
   import eeprom_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int ADDR_W   = 6,
   parameter int QUAL_LO  = 6,
   parameter int DIR_LO   = 4,
   parameter int SOUT_BIT = 4,
   localparam int CNT_W   = $clog2(DATA_W)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_stb,
   input logic              wr_sel,
   input logic [DATA_W-1:0] wr_data,
   input logic              rd_stb,
   input logic              rd_sel,
   input logic [DATA_W-1:0] rd_data,
   input logic [1:0]        pio_dir,
   input seq_state_t        state,
   input logic [1:0]        op,
   input logic [ADDR_W-1:0] addr,
   input logic [CNT_W-1:0]  cnt
);
   logic qual;
   assign qual = (wr_data[QUAL_LO+1:QUAL_LO] == 2'b11);

   AST_QUAL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !qual && !rd_stb) |=> ($stable(pio_dir) && $stable(state) && $stable(addr))); // R1
   AST_DIR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !wr_sel && qual) |=> (pio_dir == $past(wr_data[DIR_LO+1:DIR_LO]))); // R2
   AST_DIR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !wr_sel && qual && wr_data[DIR_LO+1:DIR_LO] == 2'b10) |=> (state == ST_IDLE)); // R3
   AST_RD_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data & ~(DATA_W'(1) << SOUT_BIT)) == '0); // R7
   AST_RD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (!(rd_stb && rd_sel) || state != ST_XFER || op != OP_RD) |-> (rd_data == '0)); // R8
   AST_WORD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && wr_sel && qual && !rd_stb && state == ST_XFER && op == OP_WR &&
       cnt == CNT_W'(DATA_W - 1)) |=> (addr == ADDR_W'($past(addr) + 1'b1))); // R9
   AST_XFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_XFER && !(wr_stb && !wr_sel && qual)) |=> (state == ST_XFER)); // R5
endmodule

bind serial_eeprom_resp serial_eeprom_resp_chk #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .QUAL_LO(QUAL_LO),
   .DIR_LO(DIR_LO), .SOUT_BIT(SOUT_BIT)
) i_chk (
   .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
   .wr_data(wr_data), .rd_stb(rd_stb), .rd_sel(rd_sel), .rd_data(rd_data),
   .pio_dir(pio_dir), .state(state), .op(op), .addr(addr), .cnt(cnt)
);

// File: tb/test_serial_eeprom_resp.sv
module test_serial_eeprom_resp;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_stb = 1'b0, wr_sel = 1'b0, rd_stb = 1'b0, rd_sel = 1'b0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic [1:0]  pio_dir;
   logic [15:0] ref_mem [64];
   int          total = 0, bad = 0;

   always #10 clk = ~clk;

   serial_eeprom_resp i_serial_eeprom_resp (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_stb(rd_stb), .rd_sel(rd_sel),
      .rd_data(rd_data), .pio_dir(pio_dir)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic sel, input logic [15:0] v);
      @(negedge clk);
      wr_stb = 1'b1; wr_sel = sel; wr_data = v;
      @(negedge clk);
      wr_stb = 1'b0; wr_data = '0;
   endtask

   task automatic rd(input logic sel, output logic [15:0] v);
      @(negedge clk);
      rd_stb = 1'b1; rd_sel = sel;
      #2 v = rd_data;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic send_bit(input logic b);
      wr(1'b1, 16'h00C0 | (16'(b) << 5));
   endtask

   task automatic open_session(input logic [1:0] op, input logic [5:0] a);
      wr(1'b0, 16'h00E0);
      send_bit(1'b0);
      send_bit(op[1]);
      send_bit(op[0]);
      for (int i = 5; i >= 0; i--) send_bit(a[i]);
   endtask

   task automatic write_word(input logic [5:0] a, input logic [15:0] w);
      for (int b = 15; b >= 0; b--) send_bit(w[b]);
      ref_mem[a] = w;
   endtask

   task automatic read_words(input string req, input logic [5:0] a, input int n, input logic dummy);
      logic [15:0] v;
      if (dummy) begin
         rd(1'b1, v);
         check({req, " dummy"}, 32'(v), 32'h0);
      end
      for (int w = 0; w < n; w++) begin
         logic [5:0] wa;
         wa = a + 6'(w);
         for (int b = 15; b >= 0; b--) begin
            rd(1'b1, v);
            check(req, 32'(v), 32'(ref_mem[wa][b]) << 4);
         end
      end
   endtask

   task automatic t_reset;
      logic [15:0] v;
      check("R11 pio_dir after reset", 32'(pio_dir), 32'h0);
      rd(1'b1, v);
      check("R8 read while idle", 32'(v), 32'h0);
   endtask

   task automatic t_single;
      open_session(2'b01, 6'd5);
      write_word(6'd5, 16'hA5C3);
      open_session(2'b10, 6'd5);
      read_words("R4 R5 R6 R7 single word", 6'd5, 1, 1'b1);
      check("R2 pio_dir after restart", 32'(pio_dir), 32'h2);
   endtask

   task automatic t_wrap;
      open_session(2'b01, 6'd62);
      write_word(6'd62, 16'h1234);
      write_word(6'd63, 16'h8001);
      write_word(6'd0, 16'hFFFE);
      open_session(2'b10, 6'd62);
      read_words("R9 wrap stream", 6'd62, 3, 1'b1);
   endtask

   task automatic t_qual;
      wr(1'b0, 16'h00E0);
      send_bit(1'b0);
      send_bit(1'b1);
      wr(1'b1, 16'h0020);
      wr(1'b1, 16'h0060);
      wr(1'b1, 16'h00A0);
      send_bit(1'b0);
      wr(1'b0, 16'h0050);
      check("R1 unqualified direction write", 32'(pio_dir), 32'h2);
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b0);
      wr(1'b0, 16'h00A0);
      send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
      read_words("R1 unqualified writes ignored", 6'd5, 1, 1'b1);
   endtask

   task automatic t_dir;
      wr(1'b0, 16'h00D0);
      check("R2 direction field 01", 32'(pio_dir), 32'h1);
      wr(1'b0, 16'h00E0);
      send_bit(1'b0); send_bit(1'b0); send_bit(1'b1);
      send_bit(1'b1); send_bit(1'b0);
      wr(1'b0, 16'h00E0);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      for (int i = 5; i >= 0; i--) send_bit(i != 0);
      read_words("R3 restart mid address", 6'd62, 1, 1'b1);
      wr(1'b0, 16'h00F0);
      check("R2 direction field 11", 32'(pio_dir), 32'h3);
      read_words("R3 non-restart value keeps stream", 6'd63, 1, 1'b0);
   endtask

   task automatic t_badop;
      logic [15:0] v;
      open_session(2'b01, 6'd10);
      write_word(6'd10, 16'h5A0F);
      open_session(2'b11, 6'd10);
      for (int b = 0; b < 16; b++) send_bit(b[0]);
      rd(1'b1, v);
      check("R10 read under opcode 11", 32'(v), 32'h0);
      open_session(2'b00, 6'd10);
      for (int b = 0; b < 16; b++) send_bit(~b[0]);
      rd(1'b1, v);
      check("R8 read under opcode 00", 32'(v), 32'h0);
      open_session(2'b10, 6'd10);
      read_words("R10 word unchanged", 6'd10, 1, 1'b1);
   endtask

   task automatic t_dirread;
      logic [15:0] v;
      open_session(2'b10, 6'd5);
      rd(1'b1, v);
      check("R7 dummy before dir read", 32'(v), 32'h0);
      rd(1'b0, v);
      check("R12 direction register read", 32'(v), 32'h0);
      read_words("R12 stream not advanced", 6'd5, 1, 1'b0);
   endtask

   task automatic t_rst;
      open_session(2'b10, 6'd62);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk) rst_n = 1'b1;
      #2 check("R11 pio_dir cleared", 32'(pio_dir), 32'h0);
      send_bit(1'b0); send_bit(1'b1); send_bit(1'b0);
      for (int i = 5; i >= 0; i--) send_bit((6'd10 >> i) & 1'b1);
      read_words("R11 storage kept", 6'd10, 1, 1'b1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_wrap();
      t_qual();
      t_dir();
      t_badop();
      t_dirread();
      t_rst();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule